// File: doc/BRIEF.md
# Six-channel down-counting timer

The block holds six independent down-counters behind a small 32-bit register port. Each channel has a control word, an interval word and a current-value word. A started channel decrements once per step. A step comes from one of two tick-enable inputs, a slow tick and a fast tick. A per-channel prescaler thins those ticks by a power of two. When a channel counts past zero it expires. What it does next depends on its mode. A single-shot channel stops at zero. A continuous channel either reloads from its interval word or wraps to all ones.

Each expiry sets that channel's bit in a shared pending word, whether or not the interrupt is enabled. Software clears a pending bit by writing a 1 to it. A shared enable word masks pending bits onto the single interrupt output. Software can overwrite the current value at any time, and counting goes on from the value written.

Writes take effect at the rising clock edge while `wr_en` is high. Reads are combinational from `addr`.

Top module: `dcount_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Register map:
  - enable word at 0x00 and pending word at 0x04, with bit n belonging to channel n;
  - for channel n (0 to 5), control at 0x10+0x10*n, interval at 0x14+0x10*n and current value at 0x18+0x10*n;
  - the control word reads back its 8 bits, zero-extended;
  - any other address reads 0.
- R3: A channel counts only while control bit 0 (start) is 1. Each step lowers the current value by 1.
- R4: Control bits 3:2 pick the step source: 00 is `tick_slow`, 01 is `tick_fast`, and 10 or 11 give no ticks.
- R5: Control bits 6:4 hold a prescale code p. A started channel steps once per 2^p selected ticks, so code 0 means every tick. Writing the control word restarts the prescale count.
- R6: Expiry happens on a step taken at value 0. When control bit 7 is 1 (single-shot), expiry clears the start bit and the value stays at 0.
- R7: When bit 7 is 0 and control bit 1 (auto-reload) is 1, expiry loads the interval word into the current value.
- R8: When bits 7 and 1 are both 0, expiry wraps the current value to all ones.
- R9: A write to the current value takes priority over a step in the same cycle. Counting then continues from the value written.
- R10: Expiry sets the channel's pending bit whatever the enable bit is. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If an expiry and a clear of the same bit fall in one cycle, the bit stays set.
- R11: `irq` is 1 exactly when some channel has both its pending bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| tick_slow | input | 1 | Slow step-enable tick |
| tick_fast | input | 1 | Fast step-enable tick |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle.

The first pair is an expiry and a software clear of the same pending bit. The bench starts a channel at value 0 in continuous mode. It then raises the fast tick in the very cycle that writes 1 to that channel's pending bit. The bit must read back as 1 afterwards. A second clear with no tick must then drop it to 0.

The second pair is a current-value write and a counting step. The bench writes a new value while the tick is high. It expects the written value after that edge, and one less after the next tick.

// File: rtl/dcount_timer.sv
module dcount_timer #(
  parameter int NCH = 6,
  parameter int W   = 32,
  parameter int AW  = 8,
  parameter int PSW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          tick_slow,
  input  logic          tick_fast,
  output logic          irq
);
  localparam logic [AW-1:0] EN_A   = AW'(0);
  localparam logic [AW-1:0] PEND_A = AW'(4);
  localparam int BASE = 16;
  localparam int STRIDE = 16;

  logic [NCH-1:0] ien, pend, expire;
  logic [7:0]     ctrl_q [NCH];
  logic [W-1:0]   intv_q [NCH];
  logic [W-1:0]   cur_q  [NCH];
  logic [NCH-1:0] step, wr_ctl, wr_cur;

  wire wr_en_reg  = wr_en && addr == EN_A;
  wire wr_pend    = wr_en && addr == PEND_A;
  wire [NCH-1:0] clr = wr_pend ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien  <= '0;
      pend <= '0;
    end else begin
      if (wr_en_reg) ien <= wdata[NCH-1:0];
      pend <= (pend & ~clr) | expire;
    end

  assign irq = |(pend & ien);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] CTL_A = AW'(BASE + STRIDE*i);
    localparam logic [AW-1:0] INT_A = AW'(BASE + STRIDE*i + 4);
    localparam logic [AW-1:0] CUR_A = AW'(BASE + STRIDE*i + 8);

    logic [PSW-1:0] pcnt, mask;
    logic src_tick, run_tick, wr_int;
    wire started = ctrl_q[i][0];
    wire reload  = ctrl_q[i][1];
    wire single  = ctrl_q[i][7];

    assign wr_ctl[i] = wr_en && addr == CTL_A;
    assign wr_int    = wr_en && addr == INT_A;
    assign wr_cur[i] = wr_en && addr == CUR_A;

    always_comb
      case (ctrl_q[i][3:2])
        2'b00:   src_tick = tick_slow;
        2'b01:   src_tick = tick_fast;
        default: src_tick = 1'b0;
      endcase

    assign mask      = PSW'((PSW+1)'(1) << ctrl_q[i][6:4]) - PSW'(1);
    assign run_tick  = started && src_tick;
    assign step[i]   = run_tick && ((pcnt & mask) == mask);
    assign expire[i] = step[i] && cur_q[i] == '0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ctrl_q[i] <= '0;
        intv_q[i] <= '0;
        cur_q[i]  <= '0;
        pcnt      <= '0;
      end else begin
        if (wr_ctl[i]) pcnt <= '0;
        else if (run_tick) pcnt <= pcnt + PSW'(1);

        if (wr_ctl[i]) ctrl_q[i] <= wdata[7:0];
        else if (expire[i] && single) ctrl_q[i][0] <= 1'b0;

        if (wr_int) intv_q[i] <= wdata;

        if (wr_cur[i]) cur_q[i] <= wdata;
        else if (expire[i]) cur_q[i] <= single ? '0 : reload ? intv_q[i] : '1;
        else if (step[i]) cur_q[i] <= cur_q[i] - W'(1);
      end

    // R10
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[i]) |-> $past(wr_en && addr == PEND_A && wdata[i]));
    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_q[i][0]) && !$past(wr_ctl[i])) |-> (cur_q[i] == '0 && $past(ctrl_q[i][7])));
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && !single && reload && !wr_cur[i]) |=> cur_q[i] == $past(intv_q[i]));
    // R9
    cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step[i] && !wr_cur[i]) |=> $stable(cur_q[i]));
  end

  always_comb begin
    rdata = '0;
    if (addr == EN_A)   rdata[NCH-1:0] = ien;
    if (addr == PEND_A) rdata[NCH-1:0] = pend;
    for (int k = 0; k < NCH; k++) begin
      if (addr == AW'(BASE + STRIDE*k))     rdata = {{(W-8){1'b0}}, ctrl_q[k]};
      if (addr == AW'(BASE + STRIDE*k + 4)) rdata = intv_q[k];
      if (addr == AW'(BASE + STRIDE*k + 8)) rdata = cur_q[k];
    end
  end

  // R11
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));
endmodule

// File: tb/dcount_timer_bench.sv
`timescale 1ns/1ps
module dcount_timer_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, tick_slow = 0, tick_fast = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dcount_timer u_dcount_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq));

  // per vector: channel, source code, prescale code, pulse fast(1)/slow(0), pulses, expected
  localparam int V_CH [8] = '{0, 1, 2, 3, 4, 5, 0, 1};
  localparam int V_SRC[8] = '{1, 1, 0, 0, 2, 1, 3, 0};
  localparam int V_PS [8] = '{0, 2, 0, 1, 0, 7, 0, 3};
  localparam int V_FST[8] = '{1, 1, 0, 1, 1, 1, 0, 0};
  localparam int V_N  [8] = '{10, 10, 7, 8, 5, 300, 5, 17};
  localparam int V_EXP[8] = '{990, 998, 993, 1000, 1000, 998, 1000, 998};

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(bit fast, int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (fast) tick_fast = 1; else tick_slow = 1;
    end
    @(negedge clk); tick_fast = 0; tick_slow = 0;
  endtask

  function automatic logic [7:0] ca(int ch); return 8'(16 + 16*ch); endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #23 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, v); check("R1 enable", v, 0);
    rd(8'h04, v); check("R1 pending", v, 0);
    rd(8'h10, v); check("R1 ctrl0", v, 0);
    rd(8'h68, v); check("R1 cur5", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R4 R5 R3 table
    for (int i = 0; i < 8; i++) begin
      wr(ca(V_CH[i]) + 8, 1000);
      wr(ca(V_CH[i]), 32'(1 | (V_SRC[i] << 2) | (V_PS[i] << 4)));
      pulse(V_FST[i] != 0, V_N[i]);
      rd(ca(V_CH[i]) + 8, v);
      check($sformatf("R4/R5 vector %0d", i), v, V_EXP[i]);
      wr(ca(V_CH[i]), 0);
    end

    // R2 map and readback
    wr(8'h24, 32'h1234_5678);
    rd(8'h24, v); check("R2 interval1", v, 32'h1234_5678);
    wr(8'h20, 32'hFFFF_FFB4);
    rd(8'h20, v); check("R2 ctrl8bit", v, 32'hB4);
    wr(8'h20, 0);
    rd(8'h08, v); check("R2 unmapped 08", v, 0);
    rd(8'h70, v); check("R2 unmapped 70", v, 0);

    // R3 stopped channel holds
    wr(8'h28, 77); wr(8'h20, 32'h04);
    pulse(1, 5);
    rd(8'h28, v); check("R3 stopped hold", v, 77);

    // R6 single-shot
    wr(8'h38, 3); wr(8'h30, 32'h85);
    pulse(1, 4);
    rd(8'h38, v); check("R6 at zero", v, 0);
    rd(8'h30, v); check("R6 start cleared", v, 32'h84);
    rd(8'h04, v); check("R10 pending w/o enable", v & 32'h4, 32'h4);
    check("R11 irq masked", {31'b0, irq}, 0);
    pulse(1, 3);
    rd(8'h38, v); check("R6 hold zero", v, 0);
    wr(8'h00, 32'h4);
    check("R11 irq raised", {31'b0, irq}, 1);
    wr(8'h04, 32'h3B);
    rd(8'h04, v); check("R10 write 0 keeps", v & 32'h4, 32'h4);
    wr(8'h04, 32'h4);
    rd(8'h04, v); check("R10 w1c", v & 32'h4, 0);
    check("R11 irq cleared", {31'b0, irq}, 0);

    // R7 auto-reload
    wr(8'h44, 4); wr(8'h48, 1); wr(8'h40, 32'h07);
    pulse(1, 3);
    rd(8'h48, v); check("R7 reload", v, 3);
    rd(8'h04, v); check("R7 pending", v & 32'h8, 32'h8);
    wr(8'h40, 0);

    // R8 wrap
    wr(8'h58, 0); wr(8'h50, 32'h05);
    pulse(1, 1);
    rd(8'h58, v); check("R8 wrap", v, 32'hFFFF_FFFF);
    wr(8'h50, 0);

    // R9 write vs step collision
    wr(8'h18, 100); wr(8'h10, 32'h05);
    @(negedge clk); tick_fast = 1; addr = 8'h18; wdata = 50; wr_en = 1;
    @(negedge clk); wr_en = 0;
    @(negedge clk); tick_fast = 0;
    rd(8'h18, v); check("R9 write wins then counts", v, 49);
    wr(8'h10, 0);

    // R10 expiry vs clear collision
    wr(8'h68, 0); wr(8'h60, 32'h05);
    @(negedge clk); tick_fast = 1; addr = 8'h04; wdata = 32'h20; wr_en = 1;
    @(negedge clk); wr_en = 0; tick_fast = 0;
    rd(8'h04, v); check("R10 set wins", v & 32'h20, 32'h20);
    wr(8'h60, 0);
    wr(8'h04, 32'h20);
    rd(8'h04, v); check("R10 cleared later", v & 32'h20, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule